// File: doc/BRIEF.md
# Packed Day-Time Counter with Alarms

This block keeps time for a real-time clock. A prescaler divides the 32.768 kHz input clock down to one tick per second. When the prescaler is switched off, the block ticks on every input clock instead, which is useful for fast bring-up and for test. On each tick it advances a 32-bit time word. The word packs a second field, a minute field, an hour field and a day count.

On the same tick the block compares the new time against a stored alarm word and raises one-cycle event pulses. There is a pulse for each second, for each minute carry, for each hour carry, for each midnight rollover, for a time-of-day alarm match, and for a full day-and-time alarm match. The day-and-time alarm is the one used when an alarm lies more than a day ahead.

The time word and the alarm word each load from a strobe. A load of the time word also restarts the prescaler, so the first second after a load is a full second.

Top module: `rtc_daytime_core`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, time_o reads 0 and evt_o reads 0.
- R2: time_o packs the fields as seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and days in bits 31:17. A cycle with time_ld_i high puts time_val_i on time_o in the next cycle. That cycle counts no tick and pulses no event, and the prescaler count restarts from zero.
- R3: With presc_en_i high and no load, a tick occurs once every DIV cycles. The first tick after a load or enable comes DIV cycles later.
- R4: With presc_en_i low, a tick occurs on every clock cycle.
- R5: On a tick, each field advances as follows:
  - Seconds at 59 or above wrap to 0 and carry into minutes.
  - Minutes at 59 or above wrap to 0 and carry into hours.
  - Hours at 23 or above wrap to 0 and increment the day count.
- R6: The day count wraps from 32767 to 0 and raises no event beyond those of R7.
- R7: evt_o pulses for exactly one cycle, in the cycle after the tick edge. The bits are:
  - bit 2: every tick.
  - bit 3: the seconds wrap.
  - bit 4: the minutes wrap.
  - bit 5: the hours wrap.
- R8: evt_o bit 1 pulses on a tick whose new time has bits 16:0 equal to those of the stored alarm.
- R9: evt_o bit 6 pulses on a tick whose new time equals the whole 32-bit stored alarm. It is always accompanied by bit 1.
- R10: alarm_ld_i stores alarm_val_i. A tick in the same cycle as the load still compares against the previous alarm.
- R11: evt_o bit 0 (stopwatch position) never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz timekeeping clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_en_i | input | 1 | 1: tick every DIV cycles; 0: tick every cycle |
| time_ld_i | input | 1 | Load strobe for the time word |
| time_val_i | input | 32 | Time word to load |
| alarm_ld_i | input | 1 | Load strobe for the alarm word |
| alarm_val_i | input | 32 | Alarm word to load |
| time_o | output | 32 | Current packed time |
| evt_o | output | 7 | Event pulses, one bit per event (see R7 to R11) |

## Verification
The counter is driven from loads placed just below each carry boundary: 23:59:58 on an ordinary day and on day 32767. Ripples that are too short or too long show up as field errors. The day wrap is told apart from an extra event by the pulse pattern.

Alarm cases separate the two kinds of alarm:
- a time-only match with a different day;
- a full match;
- an alarm reloaded on the very tick it would match.

Runs with the prescaler on and off, with loads landing mid-count, distinguish the tick period from a counter that fails to restart. An out-of-range seconds load checks the wrap at or above the limit.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 15;
  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = SEC_LSB + SEC_W;
  localparam int HR_LSB  = MIN_LSB + MIN_W;
  localparam int DAY_LSB = HR_LSB + HR_W;
  localparam int TOD_W   = DAY_LSB;
  localparam int TIME_W  = DAY_LSB + DAY_W;
  localparam int SEC_MAX = 59;
  localparam int MIN_MAX = 59;
  localparam int HR_MAX  = 23;
  localparam int EVT_W   = 7;
  // event bit positions
  localparam int EV_SWATCH = 0;
  localparam int EV_ALARM  = 1;
  localparam int EV_SEC    = 2;
  localparam int EV_MIN    = 3;
  localparam int EV_HR     = 4;
  localparam int EV_DAY    = 5;
  localparam int EV_DALARM = 6;

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } time_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i ? (cnt_q == LAST) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i || !en_i || tick_o) cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_chk
      // after a divided tick, the next one cannot follow immediately
      assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_o) |=> (!en_i || !tick_o));
    end
  endgenerate
endmodule

// File: rtl/rtc_time_adv.sv
module rtc_time_adv
  import rtc_pkg::*;
(
  input  time_t cur_i,
  output time_t nxt_o,
  output logic  sec_wrap_o,
  output logic  min_wrap_o,
  output logic  hr_wrap_o
);
  always_comb begin
    nxt_o      = cur_i;
    sec_wrap_o = cur_i.sec >= SEC_W'(SEC_MAX);
    min_wrap_o = sec_wrap_o && (cur_i.min >= MIN_W'(MIN_MAX));
    hr_wrap_o  = min_wrap_o && (cur_i.hr >= HR_W'(HR_MAX));
    nxt_o.sec  = sec_wrap_o ? '0 : cur_i.sec + 1'b1;
    if (sec_wrap_o) nxt_o.min = min_wrap_o ? '0 : cur_i.min + 1'b1;
    if (min_wrap_o) nxt_o.hr  = hr_wrap_o  ? '0 : cur_i.hr + 1'b1;
    if (hr_wrap_o)  nxt_o.day = cur_i.day + 1'b1;  // natural wrap at field width
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  time_t t_i,
  input  time_t alarm_i,
  output logic  tod_hit_o,
  output logic  day_hit_o
);
  logic [TIME_W-1:0] t_w, a_w;
  assign t_w       = t_i;
  assign a_w       = alarm_i;
  assign tod_hit_o = t_w[TOD_W-1:0] == a_w[TOD_W-1:0];
  assign day_hit_o = tod_hit_o && (t_i.day == alarm_i.day);
endmodule

// File: rtl/rtc_daytime_core.sv
module rtc_daytime_core
  import rtc_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              presc_en_i,
  input  logic              time_ld_i,
  input  logic [TIME_W-1:0] time_val_i,
  input  logic              alarm_ld_i,
  input  logic [TIME_W-1:0] alarm_val_i,
  output logic [TIME_W-1:0] time_o,
  output logic [EVT_W-1:0]  evt_o
);
  time_t time_q, alarm_q, nxt_time;
  logic [EVT_W-1:0] evt_q, evt_d;
  logic tick, sec_wrap, min_wrap, hr_wrap, tod_hit, day_hit;

  rtc_prescaler #(.DIV(DIV)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (presc_en_i),
    .restart_i (time_ld_i),
    .tick_o    (tick)
  );

  rtc_time_adv u_adv (
    .cur_i      (time_q),
    .nxt_o      (nxt_time),
    .sec_wrap_o (sec_wrap),
    .min_wrap_o (min_wrap),
    .hr_wrap_o  (hr_wrap)
  );

  rtc_alarm_cmp u_cmp (
    .t_i       (nxt_time),
    .alarm_i   (alarm_q),
    .tod_hit_o (tod_hit),
    .day_hit_o (day_hit)
  );

  logic adv;
  assign adv = tick && !time_ld_i;

  always_comb begin
    evt_d = '0;
    if (adv) begin
      evt_d[EV_SEC]    = 1'b1;
      evt_d[EV_MIN]    = sec_wrap;
      evt_d[EV_HR]     = min_wrap;
      evt_d[EV_DAY]    = hr_wrap;
      evt_d[EV_ALARM]  = tod_hit;
      evt_d[EV_DALARM] = day_hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      alarm_q <= '0;
      evt_q   <= '0;
    end else begin
      if (time_ld_i)  time_q <= time_t'(time_val_i);
      else if (adv)   time_q <= nxt_time;
      if (alarm_ld_i) alarm_q <= time_t'(alarm_val_i);
      evt_q <= evt_d;
    end
  end

  assign time_o = time_q;
  assign evt_o  = evt_q;

  assert_load_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_ld_i |=> (evt_o == '0));
  assert_min_with_sec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o[EV_MIN] || evt_o[EV_HR] || evt_o[EV_DAY]) |-> evt_o[EV_SEC]);
  assert_sec_wrapped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_MIN] |-> (time_o[MIN_LSB-1:SEC_LSB] == '0));
  assert_dalarm_has_tod_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_DALARM] |-> evt_o[EV_ALARM]);
  assert_swatch_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_SEC] || !evt_o[EV_SWATCH]);
endmodule

// File: tb/rtc_daytime_core_test.sv
module rtc_daytime_core_test;
  localparam int DIV = 4;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic presc_en_i = 1'b0, time_ld_i = 1'b0, alarm_ld_i = 1'b0;
  logic [31:0] time_val_i = '0, alarm_val_i = '0;
  logic [31:0] time_o;
  logic [6:0]  evt_o;

  rtc_daytime_core #(.DIV(DIV)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .presc_en_i(presc_en_i),
    .time_ld_i(time_ld_i), .time_val_i(time_val_i),
    .alarm_ld_i(alarm_ld_i), .alarm_val_i(alarm_val_i),
    .time_o(time_o), .evt_o(evt_o));

  always #2 clk_i = ~clk_i;  // 250 MHz

  int n_cmp = 0, n_bad = 0, cycles = 0;

  function automatic logic [31:0] pk(int d, int h, int m, int s);
    return {d[14:0], h[4:0], m[5:0], s[5:0]};
  endfunction

  // behavioural reference model
  int m_cnt, s, mi, h, d;
  logic m_tick;
  logic [31:0] m_time, m_alarm, nt;
  logic [6:0]  m_evt;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_time = 0; m_alarm = 0; m_evt = 0;
    end else begin
      m_evt  = 0;
      m_tick = presc_en_i ? (m_cnt == DIV - 1) : 1'b1;
      if (time_ld_i) begin
        m_time = time_val_i; m_cnt = 0;
      end else begin
        if (!presc_en_i || m_tick) m_cnt = 0; else m_cnt++;
        if (m_tick) begin
          s = m_time[5:0]; mi = m_time[11:6]; h = m_time[16:12]; d = m_time[31:17];
          m_evt[2] = 1;
          if (s >= 59) begin
            s = 0; m_evt[3] = 1;
            if (mi >= 59) begin
              mi = 0; m_evt[4] = 1;
              if (h >= 23) begin h = 0; m_evt[5] = 1; d = (d + 1) % 32768; end
              else h++;
            end else mi++;
          end else s++;
          nt = pk(d, h, mi, s);
          if (nt[16:0] == m_alarm[16:0]) m_evt[1] = 1;
          if (nt == m_alarm) m_evt[6] = 1;
          m_time = nt;
        end
      end
      if (alarm_ld_i) m_alarm = alarm_val_i;
    end
  end

  function automatic string evt_req(int b);
    case (b)
      0: return "R11";
      1: return "R8/R10";
      6: return "R9/R10";
      default: return "R7";
    endcase
  endfunction

  // compare every cycle away from the active edge
  always @(negedge clk_i) begin
    cycles++;
    n_cmp++;
    if (time_o !== m_time) begin
      n_bad++;
      $display("FAIL R2/R3/R4/R5/R6 time_o actual %h expected %h at cycle %0d",
               time_o, m_time, cycles);
    end
    for (int b = 0; b < 7; b++) begin
      n_cmp++;
      if (evt_o[b] !== m_evt[b]) begin
        n_bad++;
        $display("FAIL %s evt_o[%0d] actual %b expected %b at cycle %0d",
                 evt_req(b), b, evt_o[b], m_evt[b], cycles);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask
  task automatic ld_time(logic [31:0] v);
    @(negedge clk_i); time_ld_i = 1; time_val_i = v;
    @(negedge clk_i); time_ld_i = 0;
  endtask
  task automatic ld_alarm(logic [31:0] v);
    @(negedge clk_i); alarm_ld_i = 1; alarm_val_i = v;
    @(negedge clk_i); alarm_ld_i = 0;
  endtask

  initial begin
    // R1: reset state compared while held and just after release
    idle(3);
    @(negedge clk_i); rst_ni = 1;
    // R4: unscaled ticking from zero
    idle(70);
    // R3 with R5/R7: divided ticks through a full carry ripple
    presc_en_i = 1;
    ld_time(pk(5, 23, 59, 58));
    idle(30);
    // R2: load landing mid-count restarts the divider
    idle(2); ld_time(pk(1, 2, 3, 4)); idle(9);
    // R6: day count wrap
    ld_time(pk(32767, 23, 59, 57)); idle(20);
    // R8: time-only match, day differs
    presc_en_i = 0;
    ld_alarm(pk(99, 0, 1, 2));
    ld_time(pk(3, 0, 0, 50)); idle(30);
    // R9: full match
    ld_alarm(pk(7, 0, 0, 10));
    ld_time(pk(7, 0, 0, 0)); idle(20);
    // R10: alarm reloaded on the tick that would match old value
    ld_alarm(pk(0, 0, 0, 0));
    ld_time(pk(4, 0, 0, 5));
    @(negedge clk_i); alarm_ld_i = 1; alarm_val_i = pk(4, 0, 0, 20);
    @(negedge clk_i); alarm_ld_i = 0; idle(25);
    // R5: out-of-range seconds and hours wrap at or above limit
    ld_time(pk(9, 30, 59, 62)); idle(5);
    // R2: load and alarm load together with divider on
    presc_en_i = 1;
    @(negedge clk_i); time_ld_i = 1; time_val_i = pk(2, 10, 10, 10);
    alarm_ld_i = 1; alarm_val_i = pk(2, 10, 10, 12);
    @(negedge clk_i); time_ld_i = 0; alarm_ld_i = 0;
    idle(20);
    // R3: divider toggled off and back on mid-count
    idle(1); presc_en_i = 0; idle(2); presc_en_i = 1; idle(12);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule